// File: doc/BRIEF.md
# Three-Mode Transpose Write-Address Generator

This block sits between a one-dimensional transform stage and a block memory in a separable three-dimensional transform over an N×N×N volume. The transform stage delivers coefficients in raster order: column index fastest, then row, then slice. The block writes each qualified word into the memory at an address chosen so that reading the memory back in plain linear order returns the data along another axis. One address engine serves all three passes of the volume transform. The rowcol mode turns the rows of one slice into columns. The depth mode interleaves whole slices so that depth vectors lie next to each other. The linear mode keeps the arrival order for the final pass.

Only one counter, with three digit fields, drives every mode. A mode is sampled on the first word of a pass and is held until the pass ends. The end of a pass is shown by a one-cycle done pulse that comes out with the last write. In rowcol mode the slice field keeps its value from one pass to the next, so consecutive rowcol passes fill consecutive slices of the memory. Depth and linear passes always start from word zero.

Top module: `xpose_agen`

## Requirements
- R1: After reset, mem_we, done and busy are low, and the first rowcol pass writes slice 0.
- R2: Each cycle with in_valid high gives exactly one write in the next cycle: mem_we is high and mem_wdata equals the accepted in_data. A cycle with in_valid low gives mem_we low in the next cycle.
- R3: In rowcol mode (mode_sel code 0), the word at column c, row r of slice s is written to address s·N² + c·N + r.
- R4: A rowcol pass covers N² words. done is high for one cycle, together with the write of the last word. The next rowcol pass uses slice s+1, and the slice number wraps from N−1 back to 0.
- R5: In depth mode (code 1), the word at column c, row r of slice s is written to address (r·N + c)·N + s. The pass always begins at s = r = c = 0, whatever rowcol passes ran before it.
- R6: In linear mode (code 2), the k-th word of the pass, counting from 0, is written to address k.
- R7: Depth and linear passes cover N³ words, with a one-cycle done pulse together with the last write.
- R8: mode_sel is sampled only on the first word of a pass. Changes to it during a pass have no effect on the addresses.
- R9: busy goes high with the write of the first word of a pass and stays high until the cycle in which done is high, where it is low.
- R10: The spare mode code 3 behaves exactly like linear mode.
- R11: Cycles with in_valid low in the middle of a pass do not move the address sequence forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Pass mode: 0 rowcol, 1 depth, 2 linear, 3 spare (acts as linear) |
| in_valid | input | 1 | Qualifies in_data for this cycle |
| in_data | input | DATA_W | Coefficient from the transform stage |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 3·LOG2N | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| done | output | 1 | One-cycle pulse that comes with the last write of a pass |
| busy | output | 1 | A pass is in progress |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the one-to-one mapping from qualified input words to memory writes with unchanged data, the single-cycle shape of done and its alignment with a write, busy falling at done, and the held mode not changing during a pass. The actual address permutations cannot be shown by assertions and need the bench's full passes. These include the slice that advances and wraps across rowcol passes, the restart of depth passes at zero, the handling of the spare code, and the pass lengths. The bench also shows that pauses and mid-pass mode changes leave the address sequence unchanged.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

    typedef enum logic [1:0] {
        XM_ROWCOL = 2'd0,
        XM_DEPTH  = 2'd1,
        XM_LINEAR = 2'd2,
        XM_SPARE  = 2'd3
    } xmode_e;

    // The spare code is folded onto linear mode.
    function automatic xmode_e norm_mode(logic [1:0] code);
        xmode_e m;
        if (code == 2'd3) m = XM_LINEAR;
        else              m = xmode_e'(code);
        return m;
    endfunction

endpackage

// File: rtl/xpose_idx_cnt.sv
module xpose_idx_cnt #(
    parameter int LOG2N = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    output logic [LOG2N-1:0] col,
    output logic [LOG2N-1:0] row,
    output logic [LOG2N-1:0] slc,
    output logic             plane_end,
    output logic             vol_end
);
    localparam int AW = 3 * LOG2N;

    logic [AW-1:0]              idx_q;
    logic [AW-1:0]              base;
    logic [2:0][LOG2N-1:0]      dig;

    // A restarting pass computes from index zero, not from the stored count.
    assign base = restart ? '0 : idx_q;

    genvar g;
    generate
        for (g = 0; g < 3; g++) begin : g_digit
            assign dig[g] = base[g*LOG2N +: LOG2N];
        end
    endgenerate

    assign col       = dig[0];
    assign row       = dig[1];
    assign slc       = dig[2];
    assign plane_end = &base[2*LOG2N-1:0];
    assign vol_end   = &base;

    always_ff @(posedge clk) begin
        if (rst)       idx_q <= '0;
        else if (step) idx_q <= base + 1'b1;
    end

endmodule

// File: rtl/xpose_addr_map.sv
module xpose_addr_map
    import xpose_pkg::*;
#(
    parameter int LOG2N = 3
) (
    input  xmode_e             mode,
    input  logic [LOG2N-1:0]   col,
    input  logic [LOG2N-1:0]   row,
    input  logic [LOG2N-1:0]   slc,
    output logic [3*LOG2N-1:0] addr
);
    always_comb begin
        unique case (mode)
            XM_ROWCOL: addr = {slc, col, row};   // s*N^2 + c*N + r
            XM_DEPTH:  addr = {row, col, slc};   // (r*N + c)*N + s
            default:   addr = {slc, row, col};   // arrival order
        endcase
    end

endmodule

// File: rtl/xpose_agen.sv
module xpose_agen
    import xpose_pkg::*;
#(
    parameter int LOG2N  = 3,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode_sel,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_data,
    output logic                 mem_we,
    output logic [3*LOG2N-1:0]   mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 done,
    output logic                 busy
);
    localparam int AW = 3 * LOG2N;

    xmode_e           mode_q;
    xmode_e           m_eff;
    logic             busy_q;
    logic             restart;
    logic             last_word;
    logic [LOG2N-1:0] col, row, slc;
    logic             plane_end, vol_end;
    logic [AW-1:0]    addr_nx;

    // Outside a pass the live selection applies; inside, the held one does.
    assign m_eff     = busy_q ? mode_q : norm_mode(mode_sel);
    assign restart   = !busy_q && (m_eff != XM_ROWCOL);
    assign last_word = (m_eff == XM_ROWCOL) ? plane_end : vol_end;

    xpose_idx_cnt #(.LOG2N(LOG2N)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (in_valid),
        .restart   (restart),
        .col       (col),
        .row       (row),
        .slc       (slc),
        .plane_end (plane_end),
        .vol_end   (vol_end)
    );

    xpose_addr_map #(.LOG2N(LOG2N)) u_map (
        .mode (m_eff),
        .col  (col),
        .row  (row),
        .slc  (slc),
        .addr (addr_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= XM_ROWCOL;
            busy_q    <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
        end else begin
            mem_we <= in_valid;
            done   <= in_valid && last_word;
            if (in_valid) begin
                mem_addr  <= addr_nx;
                mem_wdata <= in_data;
                busy_q    <= !last_word;
                if (!busy_q) mode_q <= m_eff;
            end
        end
    end

    assign busy = busy_q;

    // R2: one accepted word becomes one write carrying the same data
    p_one_write_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (mem_we && mem_wdata == $past(in_data)));

    // R2: no accepted word, no write
    p_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !mem_we);

    // R4, R7: done only comes with a write
    p_done_with_write_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> mem_we);

    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: busy is low at the end of a pass
    p_busy_low_at_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: the held mode does not change inside a pass
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(mode_q));

endmodule

// File: tb/xpose_agen_bench.sv
module xpose_agen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LOG2N      = 3;
    localparam int NN         = 1 << LOG2N;
    localparam int DATA_W     = 16;
    localparam int AW         = 3 * LOG2N;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode_sel = 2'd0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              done;
    logic              busy;

    int n_checks = 0;
    int n_fails  = 0;
    int word_no  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xpose_agen #(.LOG2N(LOG2N), .DATA_W(DATA_W)) u_xpose_agen (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_valid(in_valid),
        .in_data(in_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one word, then check the write that follows it.
    task automatic push(input int exp_addr, input bit exp_done, input string req);
        logic [DATA_W-1:0] d;
        d = DATA_W'(16'h5A00 + word_no);
        word_no++;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(posedge clk);
        #1;
        check(mem_we == 1'b1, "R2 we", int'(mem_we), 1);
        check(mem_wdata == d, "R2 data", int'(mem_wdata), int'(d));
        check(int'(mem_addr) == exp_addr, req, int'(mem_addr), exp_addr);
        check(done == exp_done, "R4/R7 done", int'(done), int'(exp_done));
        check(busy == !exp_done, "R9 busy", int'(busy), int'(!exp_done));
    endtask

    task automatic gap(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
        check(mem_we == 1'b0, "R2/R11 idle we", int'(mem_we), 0);
        check(done == 1'b0, "R7 done pulse", int'(done), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(mem_we == 1'b0, "R1 we", int'(mem_we), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R3, R4, R11: one slice through rowcol mode, optionally with pauses
    task automatic t_rowcol_pass(input int s, input bit with_gaps);
        mode_sel = 2'd0;
        for (int r = 0; r < NN; r++)
            for (int c = 0; c < NN; c++) begin
                push(s*NN*NN + c*NN + r, (r == NN-1 && c == NN-1), "R3 rowcol addr");
                if (with_gaps && (r*NN + c) % 13 == 5) gap(2);
            end
        gap(1);
    endtask

    // R5, R7, R8: depth pass with mode_sel moved mid-pass
    task automatic t_depth_pass();
        mode_sel = 2'd1;
        for (int s = 0; s < NN; s++)
            for (int r = 0; r < NN; r++)
                for (int c = 0; c < NN; c++) begin
                    if (s == 0 && r == 0 && c == 2) mode_sel = 2'd0;  // R8: ignored
                    if (s == 3 && r == 1 && c == 0) mode_sel = 2'd2;  // R8: ignored
                    push((r*NN + c)*NN + s,
                         (s == NN-1 && r == NN-1 && c == NN-1), "R5/R8 depth addr");
                end
        gap(1);
    endtask

    // R6, R7, R10: linear pass with the given code
    task automatic t_linear_pass(input logic [1:0] code, input string req);
        mode_sel = code;
        for (int k = 0; k < NN*NN*NN; k++)
            push(k, (k == NN*NN*NN-1), req);
        gap(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_rowcol_pass(0, 1'b1);             // R1, R11: slice 0 with pauses
        t_rowcol_pass(1, 1'b0);             // R4: slice advances
        t_depth_pass();                     // R5: restarts at zero
        t_rowcol_pass(0, 1'b0);             // slice count back at zero
        for (int s = 1; s < NN; s++) t_rowcol_pass(s, 1'b0);
        t_rowcol_pass(0, 1'b0);             // R4: wrap after N-1
        t_linear_pass(2'd2, "R6 linear addr");
        t_linear_pass(2'd3, "R10 spare code addr");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule